// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block collects interrupt requests for a small processor core from four sources: an edge on an external pin, a level change on four port pins, a timer rollover pulse and a pulse that marks the end of a nonvolatile write. Each source sets its own sticky flag. A request reaches the core only when the source's enable and the global enable are both set. All sources share one vector address. When the core reports an instruction boundary and a request is pending, the block pushes the core's next address on a hardware return stack. It then tells the core to load the vector and clears the global enable.

The return stack is shared with ordinary subroutine calls. A plain return pops an address. A return-from-interrupt pops an address and sets the global enable again. Software writes the control byte to set enables and to clear flags. It clears the nonvolatile-write flag through its own write strobe. A port read strobe refreshes the snapshot that the port-change detector compares against.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the control byte reads 0x00, `nvm_flag` is 0, and `pc_load` and `irq_ack` are 0.
- R2: A `tmr_ovf` pulse sets control bit 2 whatever the enables are. The bit then stays set until software writes a 0 to it.
- R3: Control bit 1 is set by an edge on `ext_pin` after a two-stage synchroniser. The edge is rising when `ext_rise_sel`=1 and falling when `ext_rise_sel`=0. The opposite edge leaves the bit unchanged.
- R4: Control bit 0 is set while the synchronised `port_pins` differ from the snapshot taken at the last `port_rd` pulse (the snapshot is zero after reset). A software clear holds only once a port read has refreshed the snapshot.
- R5: A `nvm_done` pulse sets `nvm_flag`. Control bit 6 is the enable for this source.
- R6: Entry happens in a cycle where all of the following hold: `instr_done`=1, control bit 7 (global enable)=1, and some flag is set together with its enable (bit 5 with bit 2, bit 4 with bit 1, bit 3 with bit 0, bit 6 with `nvm_flag`). On the next cycle `pc_load`=1, `irq_ack`=1 and `pc_target`=0x004. Bit 7 is cleared and `next_pc` is pushed.
- R7: No entry happens without `instr_done`, with the global enable clear, or with a flag whose enable is clear.
- R8: `reti_en` pops the top address into `pc_target` with `pc_load`=1 on the next cycle and sets bit 7. `ret_en` does the same pop and leaves bit 7 unchanged.
- R9: `call_en` pushes `next_pc` on the same last-in first-out stack used by entry.
- R10: The stack holds eight entries. A ninth push wraps the pointer and overwrites the oldest entry, with no error.
- R11: In one cycle, a hardware flag set wins over a software write of 0 to that flag. In one cycle, a stack request (`reti_en`, `ret_en`, `call_en`) wins over entry, and entry waits for a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| nvm_flag_wr | input | 1 | Write strobe for the nonvolatile-write flag |
| nvm_flag_wdata | input | 1 | Value written to that flag |
| nvm_flag | output | 1 | Nonvolatile-write-complete flag |
| ext_rise_sel | input | 1 | 1: rising edge active, 0: falling edge active |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | 4 | Asynchronous port pins watched for change |
| port_rd | input | 1 | Port read strobe, latches the snapshot |
| tmr_ovf | input | 1 | Timer rollover pulse |
| nvm_done | input | 1 | Nonvolatile write complete pulse |
| instr_done | input | 1 | Current instruction completes this cycle |
| call_en | input | 1 | Subroutine call: push `next_pc` |
| ret_en | input | 1 | Plain return: pop |
| reti_en | input | 1 | Return from interrupt: pop and set global enable |
| next_pc | input | 13 | Return address to push |
| pc_load | output | 1 | Core loads `pc_target` |
| pc_target | output | 13 | Vector or popped address |
| irq_ack | output | 1 | Interrupt entry taken |

## Verification
Two pairs of events can fall in one cycle. The first pair is a hardware flag set and a software write that clears the same flag. The bench provokes it by driving `tmr_ovf` with a control write of 0x00 in the same cycle. It also holds the port pins away from a stale snapshot while clearing the port flag. In both cases it expects the flag to read back as 1. The second pair is `reti_en` and an entry-ready `instr_done`. Here the bench expects a pop with no `irq_ack`, and then an entry at the next boundary.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int CTL_GIE    = 7;
  localparam int CTL_NVM_EN = 6;
  localparam int CTL_TMR_EN = 5;
  localparam int CTL_EXT_EN = 4;
  localparam int CTL_CHG_EN = 3;
  localparam int CTL_TMR_FL = 2;
  localparam int CTL_EXT_FL = 1;
  localparam int CTL_CHG_FL = 0;

  typedef logic [7:0] ctl_t;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_prev
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg      <= '0;
      pin_prev <= '0;
    end else begin
      stg[0] <= pin_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      pin_prev <= stg[STAGES-1];
    end
  end

  assign pin_sync = stg[STAGES-1];

  // R3: the delayed copy trails the synchronised value by one cycle
  assert_prev_lag_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pin_prev == $past(pin_sync));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_vec_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_wr,
  input  ctl_t            ctl_wdata,
  input  logic            nvm_wr,
  input  logic            nvm_wdata,
  input  logic            ext_rise_sel,
  input  logic            ext_s,
  input  logic            ext_p,
  input  logic [NPIN-1:0] port_s,
  input  logic            port_rd,
  input  logic            tmr_ovf,
  input  logic            nvm_done,
  input  logic            gie_clr,
  input  logic            gie_set,
  output ctl_t            ctl_q,
  output logic            nvm_q,
  output logic            pending
);
  logic [NPIN-1:0] snap_q;
  logic            ext_edge;
  logic            chg_hit;
  ctl_t            ctl_n;
  logic            nvm_n;

  assign ext_edge = ext_rise_sel ? (ext_s & ~ext_p) : (~ext_s & ext_p);
  assign chg_hit  = (port_s != snap_q);

  always_comb begin
    ctl_n = ctl_wr ? ctl_wdata : ctl_q;
    if (tmr_ovf)  ctl_n[CTL_TMR_FL] = 1'b1;
    if (ext_edge) ctl_n[CTL_EXT_FL] = 1'b1;
    if (chg_hit)  ctl_n[CTL_CHG_FL] = 1'b1;
    if (gie_set)  ctl_n[CTL_GIE]    = 1'b1;
    if (gie_clr)  ctl_n[CTL_GIE]    = 1'b0;
    nvm_n = nvm_wr ? nvm_wdata : nvm_q;
    if (nvm_done) nvm_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      nvm_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      nvm_q <= nvm_n;
      if (port_rd) snap_q <= port_s;
    end
  end

  assign pending = ctl_q[CTL_GIE] &
                   ((ctl_q[CTL_TMR_EN] & ctl_q[CTL_TMR_FL]) |
                    (ctl_q[CTL_EXT_EN] & ctl_q[CTL_EXT_FL]) |
                    (ctl_q[CTL_CHG_EN] & ctl_q[CTL_CHG_FL]) |
                    (ctl_q[CTL_NVM_EN] & nvm_q));

  assert_tmr_flag_R2: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf |=> ctl_q[CTL_TMR_FL]);
  assert_ext_flag_R3: assert property (@(posedge clk) disable iff (rst)
    ext_edge |=> ctl_q[CTL_EXT_FL]);
  assert_chg_flag_R4: assert property (@(posedge clk) disable iff (rst)
    chg_hit |=> ctl_q[CTL_CHG_FL]);
  assert_nvm_flag_R5: assert property (@(posedge clk) disable iff (rst)
    nvm_done |=> nvm_q);
  assert_gie_entry_R6: assert property (@(posedge clk) disable iff (rst)
    gie_clr |=> !ctl_q[CTL_GIE]);
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack
  import irq_vec_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] sp;
  logic [PW-1:0] top_idx;

  assign top_idx = sp - 1'b1;

  always_ff @(posedge clk) begin
    if (op == STK_PUSH) mem[sp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp    <= '0;
      rdata <= '0;
    end else begin
      case (op)
        STK_PUSH: sp <= sp + 1'b1;
        STK_POP: begin
          rdata <= mem[top_idx];
          sp    <= top_idx;
        end
        default: ;
      endcase
    end
  end

  assert_push_step_R9: assert property (@(posedge clk) disable iff (rst)
    (op == STK_PUSH) |=> sp == PW'($past(sp) + 1));
  assert_pop_step_R8: assert property (@(posedge clk) disable iff (rst)
    (op == STK_POP) |=> sp == PW'($past(sp) - 1));
  assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (op == STK_PUSH && sp == PW'(DEPTH - 1)) |=> sp == '0);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int AW       = 13,
  parameter int DEPTH    = 8,
  parameter int NPIN     = 4,
  parameter int SYNC     = 2,
  parameter int VEC_ADDR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_wr,
  input  logic [7:0]      ctl_wdata,
  output logic [7:0]      ctl_rdata,
  input  logic            nvm_flag_wr,
  input  logic            nvm_flag_wdata,
  output logic            nvm_flag,
  input  logic            ext_rise_sel,
  input  logic            ext_pin,
  input  logic [NPIN-1:0] port_pins,
  input  logic            port_rd,
  input  logic            tmr_ovf,
  input  logic            nvm_done,
  input  logic            instr_done,
  input  logic            call_en,
  input  logic            ret_en,
  input  logic            reti_en,
  input  logic [AW-1:0]   next_pc,
  output logic            pc_load,
  output logic [AW-1:0]   pc_target,
  output logic            irq_ack
);
  localparam logic [AW-1:0] VEC = AW'(VEC_ADDR);

  logic            ext_s, ext_p;
  logic [NPIN-1:0] port_s, port_p;
  logic            pending, take, do_pop, do_call;
  stk_op_e         op;
  logic [AW-1:0]   stk_rdata;
  logic            vec_sel_q;
  ctl_t            ctl_q;

  irq_pin_sync #(.W(1), .STAGES(SYNC)) u_ext_sync (
    .clk(clk), .rst(rst), .pin_in(ext_pin), .pin_sync(ext_s), .pin_prev(ext_p));

  irq_pin_sync #(.W(NPIN), .STAGES(SYNC)) u_port_sync (
    .clk(clk), .rst(rst), .pin_in(port_pins), .pin_sync(port_s), .pin_prev(port_p));

  assign do_pop  = reti_en | ret_en;
  assign do_call = call_en & ~do_pop;
  assign take    = instr_done & pending & ~(do_pop | call_en);

  always_comb begin
    if (do_pop)              op = STK_POP;
    else if (do_call | take) op = STK_PUSH;
    else                     op = STK_IDLE;
  end

  irq_flag_bank #(.NPIN(NPIN)) u_flags (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .nvm_wr(nvm_flag_wr), .nvm_wdata(nvm_flag_wdata),
    .ext_rise_sel(ext_rise_sel), .ext_s(ext_s), .ext_p(ext_p),
    .port_s(port_s), .port_rd(port_rd),
    .tmr_ovf(tmr_ovf), .nvm_done(nvm_done),
    .gie_clr(take), .gie_set(reti_en),
    .ctl_q(ctl_q), .nvm_q(nvm_flag), .pending(pending));

  irq_ret_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk(clk), .rst(rst), .op(op), .wdata(next_pc), .rdata(stk_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load   <= 1'b0;
      irq_ack   <= 1'b0;
      vec_sel_q <= 1'b0;
    end else begin
      pc_load   <= take | do_pop;
      irq_ack   <= take;
      vec_sel_q <= take;
    end
  end

  assign pc_target = vec_sel_q ? VEC : stk_rdata;
  assign ctl_rdata = ctl_q;

  // port_p is a delayed copy kept for symmetry of the synchroniser; change
  // detection compares against the read snapshot instead
  logic unused_port_p;
  assign unused_port_p = ^port_p;

  assert_vector_R6: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (pc_load && pc_target == VEC && !ctl_rdata[CTL_GIE]));
  assert_no_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (!instr_done || !ctl_rdata[CTL_GIE]) |=> !irq_ack);
  assert_reti_gie_R8: assert property (@(posedge clk) disable iff (rst)
    reti_en |=> (ctl_rdata[CTL_GIE] && pc_load && !irq_ack));
  assert_stack_first_R11: assert property (@(posedge clk) disable iff (rst)
    (call_en || ret_en || reti_en) |=> !irq_ack);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 0, nvm_flag_wr = 0, nvm_flag_wdata = 0;
  logic [7:0]  ctl_wdata = 0, ctl_rdata;
  logic        nvm_flag, ext_rise_sel = 1, ext_pin = 0;
  logic [3:0]  port_pins = 0;
  logic        port_rd = 0, tmr_ovf = 0, nvm_done = 0, instr_done = 0;
  logic        call_en = 0, ret_en = 0, reti_en = 0;
  logic [12:0] next_pc = 0, pc_target;
  logic        pc_load, irq_ack;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .nvm_flag_wr(nvm_flag_wr), .nvm_flag_wdata(nvm_flag_wdata), .nvm_flag(nvm_flag),
    .ext_rise_sel(ext_rise_sel), .ext_pin(ext_pin), .port_pins(port_pins), .port_rd(port_rd),
    .tmr_ovf(tmr_ovf), .nvm_done(nvm_done), .instr_done(instr_done), .call_en(call_en),
    .ret_en(ret_en), .reti_en(reti_en), .next_pc(next_pc), .pc_load(pc_load),
    .pc_target(pc_target), .irq_ack(irq_ack));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; tick(1); ctl_wr = 0;
  endtask

  task automatic boundary(input logic [12:0] pc);
    instr_done = 1; next_pc = pc; tick(1); instr_done = 0;
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 nvm", nvm_flag, 0);
    chk("R1 pc_load", pc_load, 0);
    chk("R1 irq_ack", irq_ack, 0);
  endtask

  task automatic t_timer;
    tmr_ovf = 1; tick(1); tmr_ovf = 0;
    chk("R2 set", ctl_rdata, 8'h04);
    tick(3);
    chk("R2 sticky", ctl_rdata, 8'h04);
    wr_ctl(8'h00);
    chk("R2 clear", ctl_rdata, 8'h00);
  endtask

  task automatic t_ext;
    ext_rise_sel = 1; ext_pin = 1; tick(4);
    chk("R3 rising", ctl_rdata, 8'h02);
    wr_ctl(8'h00); ext_pin = 0; tick(4);
    chk("R3 falling ignored", ctl_rdata, 8'h00);
    ext_rise_sel = 0; ext_pin = 1; tick(4);
    chk("R3 rising ignored", ctl_rdata, 8'h00);
    ext_pin = 0; tick(4);
    chk("R3 falling", ctl_rdata, 8'h02);
    wr_ctl(8'h00); ext_rise_sel = 1;
  endtask

  task automatic t_port;
    port_pins = 4'b0100; tick(4);
    chk("R4 change", ctl_rdata, 8'h01);
    wr_ctl(8'h00);
    chk("R4 stale snapshot", ctl_rdata, 8'h01);
    port_rd = 1; tick(1); port_rd = 0;
    wr_ctl(8'h00); tick(2);
    chk("R4 cleared", ctl_rdata, 8'h00);
  endtask

  task automatic t_nvm;
    nvm_done = 1; tick(1); nvm_done = 0;
    chk("R5 flag", nvm_flag, 1);
    wr_ctl(8'hC0);
    boundary(13'h055);
    chk("R5 entry", irq_ack, 1);
    chk("R5 vector", pc_target, 13'h004);
    chk("R6 gie clr", ctl_rdata, 8'h40);
    nvm_flag_wr = 1; nvm_flag_wdata = 0; tick(1); nvm_flag_wr = 0;
    chk("R5 clear", nvm_flag, 0);
    reti_en = 1; tick(1); reti_en = 0;
    chk("R8 reti addr", pc_target, 13'h055);
    wr_ctl(8'h00);
  endtask

  task automatic t_entry;
    wr_ctl(8'h20);
    tmr_ovf = 1; tick(1); tmr_ovf = 0;
    boundary(13'h011);
    chk("R7 gie off", pc_load, 0);
    wr_ctl(8'hA4); tick(2);
    chk("R7 no boundary", pc_load, 0);
    boundary(13'h123);
    chk("R6 ack", irq_ack, 1);
    chk("R6 load", pc_load, 1);
    chk("R6 vector", pc_target, 13'h004);
    chk("R6 gie clr", ctl_rdata, 8'h24);
    wr_ctl(8'h20);
    reti_en = 1; tick(1); reti_en = 0;
    chk("R8 reti load", pc_load, 1);
    chk("R8 reti no ack", irq_ack, 0);
    chk("R8 reti addr", pc_target, 13'h123);
    chk("R8 gie set", ctl_rdata, 8'hA0);
    wr_ctl(8'h84);
    boundary(13'h022);
    chk("R7 not enabled", pc_load, 0);
    call_en = 1; next_pc = 13'h0AA; tick(1); call_en = 0;
    chk("R9 call no load", pc_load, 0);
    ret_en = 1; tick(1); ret_en = 0;
    chk("R9 ret addr", pc_target, 13'h0AA);
    chk("R8 ret gie kept", ctl_rdata, 8'h84);
    wr_ctl(8'h00);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 9; i++) begin
      call_en = 1; next_pc = 13'(13'h100 + i); tick(1);
    end
    call_en = 0;
    for (int k = 0; k < 9; k++) begin
      ret_en = 1; tick(1);
      chk("R10 pop", pc_target, (k == 8) ? 13'h108 : 13'h108 - k);
    end
    ret_en = 0;
  endtask

  task automatic t_collide;
    wr_ctl(8'hA4);
    reti_en = 1; instr_done = 1; next_pc = 13'h033; tick(1);
    reti_en = 0; instr_done = 0;
    chk("R11 pop wins", pc_load, 1);
    chk("R11 entry deferred", irq_ack, 0);
    boundary(13'h034);
    chk("R11 entry later", irq_ack, 1);
    ctl_wr = 1; ctl_wdata = 8'h00; tmr_ovf = 1; tick(1);
    ctl_wr = 0; tmr_ovf = 0;
    chk("R11 set beats clear", ctl_rdata, 8'h04);
    wr_ctl(8'h00);
    chk("R11 clear after", ctl_rdata, 8'h00);
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    t_reset();
    t_timer();
    t_ext();
    t_port();
    t_nvm();
    t_entry();
    t_wrap();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule